// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins on a simple 32-bit register bus with address, write strobe, write data and combinational read data. Every pin has a control word of its own. The word holds the input, output, pad-driver and interrupt enables, plus a 3-bit trigger selector. The selector picks one of five trigger kinds: active-high level, active-low level, rising edge, falling edge, or any edge.

Three registers are shared by all pins:
- a pending register, cleared by writing ones;
- a read-only view of the synchronized pin levels;
- the output value register.

Each pin input passes through a two-flop synchronizer. The synchronized level feeds the input view and the trigger logic. The pending bits are also driven out as a vector, so an external interrupt controller can use them.

Software sets up a pin by writing its control word. For interrupts, it enables both the input and the interrupt. It then services events by reading the pending register and writing back the bits it has handled. A level trigger sets its bit again on every cycle that the level stays active, so it can only be silenced by removing the level or disarming the pin.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, every control word, the output register and every pending bit are 0, so `pin_oe`, `pin_out` and `irq_pending` are all 0.
- R2: The control word of pin i sits at byte address 4*i. Its bits are: output enable at bit 0, input enable at bit 1, driver enable at bit 2, interrupt enable at bit 3, and trigger at bits 7:5. Bit 4 and bits 31:8 read 0. An address with a nonzero low two bits, or any unmapped word, reads 0 and ignores writes.
- R3: `pin_oe[i]` is 1 only when both the output enable and the driver enable of pin i are 1. Otherwise the pad is released.
- R4: The output register at 0x88 stores all 32 written bits, reads back unchanged, and drives `pin_out`.
- R5: The input register at 0x84 returns each pin's level as sampled two clock edges earlier. Writes to it have no effect.
- R6: Trigger 000 (level high) and 001 (level low) set the pending bit on every cycle the synchronized level is active. This includes the cycle right after a clear.
- R7: Trigger 010 sets the pending bit once per 0-to-1 change of the synchronized level. Trigger 011 does the same once per 1-to-0 change.
- R8: Trigger 100 sets the pending bit once on each change of the synchronized level, in either direction.
- R9: A pin can only set its pending bit when both its interrupt enable and its input enable are 1.
- R10: Trigger codes 101, 110 and 111 never set a pending bit.
- R11: Writing 1 to bit i of the pending register at 0x80 clears pin i's pending bit. Writing 0 leaves it unchanged.
- R12: If a clear and a qualifying event hit the same pin in the same cycle, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, captured on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Pad drive enable per pin; 0 releases the pad |
| irq_pending | output | 32 | Pending interrupt flag per pin |

## Verification
Several pins are armed at once, each with a different trigger kind, and all of them see the same toggling inputs. A single toggle therefore shows at once whether rising, falling, any-edge and level kinds are told apart correctly. Other pins get reserved codes, or are missing their input or interrupt enable, and see the same toggles; these show that the gating is exact. Clears are swept one cycle at a time across an edge and across a held level, which separates the case where the event wins from a plain clear. The write-zero and read-only-register patterns show that those writes leave state alone.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W       = 32;
    localparam int TRIG_W      = 3;
    localparam int MAX_PINS    = 32;

    // word indices (byte address / 4) of the shared registers
    localparam int WIDX_PEND   = 32;
    localparam int WIDX_LEVEL  = 33;
    localparam int WIDX_DRIVE  = 34;

    // control word bit positions
    localparam int CB_OUT      = 0;
    localparam int CB_IN       = 1;
    localparam int CB_DRV      = 2;
    localparam int CB_IRQ      = 3;
    localparam int CB_TRIG_LO  = 5;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LVL_HI = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_ANY    = 3'd4
    } trig_kind_e;

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic              irq_en;
        logic              drv_en;
        logic              in_en;
        logic              out_en;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        pin_cfg_t c;
        c.out_en = w[CB_OUT];
        c.in_en  = w[CB_IN];
        c.drv_en = w[CB_DRV];
        c.irq_en = w[CB_IRQ];
        c.trig   = w[CB_TRIG_LO +: TRIG_W];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_to_word(input pin_cfg_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CB_OUT] = c.out_en;
        w[CB_IN]  = c.in_en;
        w[CB_DRV] = c.drv_en;
        w[CB_IRQ] = c.irq_en;
        w[CB_TRIG_LO +: TRIG_W] = c.trig;
        return w;
    endfunction

    // does the trigger kind fire for this level pair; reserved codes never do
    function automatic logic trig_fires(input logic [TRIG_W-1:0] trig,
                                        input logic cur, input logic prev);
        logic f;
        case (trig)
            TRIG_LVL_HI: f = cur;
            TRIG_LVL_LO: f = ~cur;
            TRIG_RISE:   f = cur & ~prev;
            TRIG_FALL:   f = ~cur & prev;
            TRIG_ANY:    f = cur ^ prev;
            default:     f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_raw,
    input  logic              armed,
    input  logic [TRIG_W-1:0] trig,
    input  logic              clr,
    output logic              level,
    output logic              pending
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_level;
    logic                   fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain      <= '0;
            prev_level <= 1'b0;
        end else begin
            chain      <= {chain[SYNC_STAGES-2:0], pin_raw};
            prev_level <= chain[SYNC_STAGES-1];
        end
    end

    assign level = chain[SYNC_STAGES-1];
    assign fire  = armed & trig_fires(trig, level, prev_level);

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else
            pending <= fire | (pending & ~clr);
    end

    // R9
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(armed));

    // R10
    reserved_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> ($past(trig) <= 3'd4));

    // R6
    level_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && trig == TRIG_LVL_HI && level) |=> pending);

    // R7
    rise_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && trig == TRIG_RISE && level && !prev_level) |=> pending);

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !armed) |=> !pending);

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wen,
    input  logic [BUS_W-1:0]             bus_wdata,
    output logic [BUS_W-1:0]             bus_rdata,
    input  logic [NUM_PINS-1:0]          levels,
    input  logic [NUM_PINS-1:0]          pend,
    output pin_cfg_t [NUM_PINS-1:0]      cfg,
    output logic [NUM_PINS-1:0]          drive_q,
    output logic [NUM_PINS-1:0]          clr_vec
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              wr_drive;
    logic              wr_pend;

    assign widx     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_drive = bus_wen && aligned && (int'(widx) == WIDX_DRIVE);
    assign wr_pend  = bus_wen && aligned && (int'(widx) == WIDX_PEND);
    assign clr_vec  = wr_pend ? bus_wdata[NUM_PINS-1:0] : '0;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg[i] <= '0;
            else if (bus_wen && aligned && int'(widx) == i)
                cfg[i] <= cfg_from_word(bus_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            drive_q <= '0;
        else if (wr_drive)
            drive_q <= bus_wdata[NUM_PINS-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (int'(widx) < NUM_PINS)
                bus_rdata = cfg_to_word(cfg[widx[$clog2(MAX_PINS)-1:0] % NUM_PINS]);
            else if (int'(widx) == WIDX_PEND)
                bus_rdata[NUM_PINS-1:0] = pend;
            else if (int'(widx) == WIDX_LEVEL)
                bus_rdata[NUM_PINS-1:0] = levels;
            else if (int'(widx) == WIDX_DRIVE)
                bus_rdata[NUM_PINS-1:0] = drive_q;
        end
    end

    // R4
    drive_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_drive |=> drive_q == $past(bus_wdata[NUM_PINS-1:0]));

    // R2
    ctrl_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (aligned && int'(widx) < NUM_PINS) |-> (bus_rdata[4] == 1'b0 && bus_rdata[BUS_W-1:8] == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wen,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] irq_pending
);

    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]     levels;
    logic [NUM_PINS-1:0]     clr_vec;

    gpio_reg_file #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .levels    (levels),
        .pend      (irq_pending),
        .cfg       (cfg),
        .drive_q   (pin_out),
        .clr_vec   (clr_vec)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpio_pin_slice #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .pin_raw (pin_in[i]),
            .armed   (cfg[i].irq_en & cfg[i].in_en),
            .trig    (cfg[i].trig),
            .clr     (clr_vec[i]),
            .level   (levels[i]),
            .pending (irq_pending[i])
        );

        assign pin_oe[i] = cfg[i].out_en & cfg[i].drv_en;

        // R11
        keep_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wen && bus_addr == 8'h80 && !bus_wdata[i] && irq_pending[i]) |=> irq_pending[i]);
    end

endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/100ps
module gpio_irq_bank_tb;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    bus_addr;
    logic          bus_wen;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] irq_pending;

    always #2.5 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wen (bus_wen),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
        .pin_out (pin_out), .pin_oe (pin_oe), .irq_pending (irq_pending)
    );

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int unsigned   m_ctrl [NP];
    logic [NP-1:0] m_out, m_s1, m_s2, m_s2d, m_pend;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int w;
        w = a / 4;
        if (a % 4 != 0) return 32'h0;
        if (w < NP) return m_ctrl[w];
        if (w == 32) return m_pend;
        if (w == 33) return m_s2;
        if (w == 34) return m_out;
        return 32'h0;
    endfunction

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        int unsigned   n_ctrl [NP];
        logic [NP-1:0] n_out, n_pend;
        logic [NP-1:0] exp_oe;
        for (int p = 0; p < NP; p++) begin
            int unsigned c;
            int t;
            bit hit, clr, cur, pv;
            c   = m_ctrl[p];
            t   = (c >> 5) & 7;
            cur = m_s2[p];
            pv  = m_s2d[p];
            case (t)
                0: hit = cur;
                1: hit = !cur;
                2: hit = cur && !pv;
                3: hit = !cur && pv;
                4: hit = cur != pv;
                default: hit = 0;
            endcase
            clr = bus_wen && bus_addr == 8'h80 && bus_wdata[p];
            n_pend[p] = (((c >> 1) & 1) == 1 && ((c >> 3) & 1) == 1 && hit) || (m_pend[p] && !clr);
            n_ctrl[p] = c;
        end
        n_out = m_out;
        if (bus_wen && bus_addr % 4 == 0) begin
            if (bus_addr / 4 < NP) n_ctrl[bus_addr / 4] = bus_wdata & 32'hEF;
            if (bus_addr / 4 == 34) n_out = bus_wdata;
        end
        @(posedge clk);
        #1;
        cycles++;
        if (rst) begin
            for (int p = 0; p < NP; p++) m_ctrl[p] = 0;
            m_out = '0; m_s1 = '0; m_s2 = '0; m_s2d = '0; m_pend = '0;
        end else begin
            m_s2d = m_s2;
            m_s2  = m_s1;
            m_s1  = pin_in;
            for (int p = 0; p < NP; p++) m_ctrl[p] = n_ctrl[p];
            m_out  = n_out;
            m_pend = n_pend;
        end
        #1;
        for (int p = 0; p < NP; p++) exp_oe[p] = (m_ctrl[p] & 32'h5) == 32'h5;
        cmp("rdata", bus_rdata, m_read(bus_addr));
        cmp("pin_out", pin_out, m_out);
        cmp("pin_oe", pin_oe, exp_oe);
        cmp("irq_pending", irq_pending, m_pend);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        tick();
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a;
        tick();
    endtask

    // watchdog
    initial begin
        #(5ns * 150000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = 8'h00; bus_wen = 1'b0; bus_wdata = '0; pin_in = '0;
        for (int p = 0; p < NP; p++) m_ctrl[p] = 0;
        m_out = '0; m_s1 = '0; m_s2 = '0; m_s2d = '0; m_pend = '0;

        tag = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);

        tag = "R2";
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
        wr(8'h7C, 32'h1234_5678); rd(8'h7C);
        wr(8'h8C, 32'hFFFF_FFFF); rd(8'h8C);
        wr(8'h09, 32'hFFFF_FFFF); rd(8'h09); rd(8'h08);
        rd(8'hFC);

        tag = "R3";
        wr(8'h0C, 32'h1); rd(8'h0C);
        wr(8'h0C, 32'h4); rd(8'h0C);
        wr(8'h0C, 32'h5); rd(8'h0C);
        wr(8'h00, 32'h0); wr(8'h0C, 32'h0);
        wr(8'h7C, 32'h0);

        tag = "R4";
        wr(8'h88, 32'hA5A5_1234); rd(8'h88);
        wr(8'h88, 32'h5A5A_EDCB); rd(8'h88);

        tag = "R5";
        bus_addr = 8'h84;
        pin_in = 32'hDEAD_BEEF; idle(4);
        pin_in = 32'h0F0F_00FF; idle(3);
        wr(8'h84, 32'hFFFF_FFFF); rd(8'h84);
        pin_in = '0; idle(3);

        tag = "R9";
        wr(8'h00, 32'h0A);  // pin0 level high
        wr(8'h04, 32'h2A);  // pin1 level low (fires at once)
        wr(8'h08, 32'h4A);  // pin2 rising
        wr(8'h0C, 32'h6A);  // pin3 falling
        wr(8'h10, 32'h8A);  // pin4 any edge
        wr(8'h14, 32'hAA);  // pin5 reserved 101
        wr(8'h18, 32'h48);  // pin6 rising, input off
        wr(8'h1C, 32'h42);  // pin7 rising, irq off
        wr(8'h20, 32'hEA);  // pin8 reserved 111
        wr(8'h24, 32'hCA);  // pin9 reserved 110
        bus_addr = 8'h80;
        idle(3);
        wr(8'h80, 32'hFFFF_FFFF);
        idle(2);

        tag = "R7";
        pin_in = 32'h0000_03FC; idle(5);
        tag = "R11";
        wr(8'h80, 32'h0000_0000); idle(1);
        wr(8'h80, 32'h0000_0004); idle(1);
        wr(8'h80, 32'hFFFF_FFFE); idle(1);
        tag = "R10";
        pin_in = 32'h0000_0000; idle(5);
        wr(8'h80, 32'hFFFF_FFFF); idle(2);

        tag = "R8";
        for (int k = 0; k < 6; k++) begin
            pin_in[4] = ~pin_in[4];
            pin_in[5] = ~pin_in[5];
            pin_in[8] = ~pin_in[8];
            idle(3);
            wr(8'h80, 32'h0000_0010);
        end

        tag = "R6";
        pin_in[0] = 1'b1; idle(4);
        wr(8'h80, 32'h0000_0003); idle(2);
        pin_in[0] = 1'b0; idle(3);
        wr(8'h80, 32'h0000_0001); idle(2);
        pin_in[1] = 1'b1; idle(3);
        wr(8'h80, 32'h0000_0002); idle(2);

        tag = "R12";
        for (int k = 0; k < 5; k++) begin
            pin_in[2] = 1'b0; idle(4);
            wr(8'h80, 32'hFFFF_FFFF);
            pin_in[2] = 1'b1;
            idle(k);
            wr(8'h80, 32'h0000_0004);
            idle(3);
        end
        pin_in[0] = 1'b1; idle(3);
        for (int k = 0; k < 3; k++) wr(8'h80, 32'h0000_0001);
        idle(2);

        tag = "R1";
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        pin_in = '0; idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule